// File: doc/BRIEF.md
# Packet Router Byte Datapath with Parity Check

This block is the byte path of a single-input packet router. A separate control state machine drives it with one strobe per state: address decode, header load, payload load, FIFO-full stall, replay after the stall, and a clear of the low-valid flag. The datapath captures the header byte and presents it to the FIFO write bus. It then forwards payload bytes as they arrive. A byte that turns up while the selected FIFO is full is parked in a holding register and replayed once the FIFO has room.

Alongside the byte path, the block keeps a running XOR of the header and every payload byte. It captures the trailing parity byte of the packet. Once the parity byte has been taken, it flags a mismatch between the two values. It also produces two handshake flags for the state machine. `par_done` says the parity byte has reached the FIFO path. `low_valid` says the input valid has dropped for the current packet.

Top module: `pkt_datapath`

## Requirements
- R1: While `rst_n` is low, `out_byte` is 0 and `par_done`, `low_valid` and `par_err` are 0.
- R2: When `st_decode` and `in_valid` are both high at a rising edge, `in_byte` is stored as the header. `st_decode` with `in_valid` low leaves the stored header unchanged. A rising edge with `st_hdr` high puts the stored header on `out_byte`.
- R3: A rising edge with `st_load` high and `fifo_full` low puts `in_byte` on `out_byte`.
- R4: A rising edge with `st_load` and `fifo_full` both high leaves `out_byte` unchanged and stores `in_byte` in a holding register. A later edge with `st_replay` high puts the held byte on `out_byte`.
- R5: `par_done` is cleared by `st_decode`. It is set by `st_load` with both `fifo_full` and `in_valid` low. It is also set by `st_replay` while `low_valid` is high and `par_done` is low. In all other cases it holds.
- R6: `low_valid` is set by `st_load` with `in_valid` low and cleared by `clr_low`. When both apply at the same edge, the clear wins.
- R7: The internal parity is cleared by `st_decode`. It XORs in the stored header on `st_hdr` and XORs in `in_byte` on `st_load` with `in_valid` high. It does not change while `st_stall` is high.
- R8: `in_byte` is captured as the packet parity on `st_load` with `in_valid` low. At the edge one cycle after `par_done` rises, `par_err` becomes 1 if the packet parity differs from the internal parity and 0 otherwise. At every other edge it holds its value.
- R9: With no strobe active, `out_byte`, `par_done`, `low_valid` and `par_err` hold their values whatever `in_byte`, `in_valid` and `fifo_full` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input packet valid |
| in_byte | input | W | Input byte (header, payload or parity) |
| fifo_full | input | 1 | Full status of the selected output FIFO |
| st_decode | input | 1 | Strobe: address decode state |
| st_hdr | input | 1 | Strobe: header load state |
| st_load | input | 1 | Strobe: payload load state |
| st_stall | input | 1 | Strobe: FIFO-full stall state |
| st_replay | input | 1 | Strobe: load-after-full replay state |
| clr_low | input | 1 | Clears the low-valid flag |
| out_byte | output | W | Byte to the FIFO write data |
| par_done | output | 1 | Parity byte has been passed on |
| low_valid | output | 1 | Input valid dropped for this packet |
| par_err | output | 1 | Packet parity mismatch |

## Verification
The assertions check several rules on every cycle. A live payload byte must appear on the output one edge later, and a stalled byte must leave the output untouched. Decode must clear the done flag, and the low-valid flag must follow its set and clear rules with the clear taking priority. The internal parity must stay frozen during a stall, and the error flag must take the parity comparison exactly one cycle after done rises. Other behaviour needs whole scenarios from the bench. These include header capture being skipped when valid is low, and the replay of a parked payload byte and of a parked parity byte. They also include the done flag being set on the replay path, and the error result for clean and corrupted packets of several lengths, including no payload at all.

// File: rtl/pdp_pkg.sv
package pdp_pkg;

    // Source selection for the byte driven towards the FIFO write bus.
    typedef enum logic [1:0] {
        SEL_KEEP  = 2'd0,
        SEL_HDR   = 2'd1,
        SEL_LIVE  = 2'd2,
        SEL_STASH = 2'd3
    } out_sel_t;

    // Priority: header strobe, then live payload, then replay of held byte.
    function automatic out_sel_t pick_src(input logic hdr, input logic load,
                                          input logic full, input logic replay);
        if (hdr)               return SEL_HDR;
        else if (load && !full) return SEL_LIVE;
        else if (replay)        return SEL_STASH;
        else                    return SEL_KEEP;
    endfunction

endpackage

// File: rtl/pdp_fwd.sv
module pdp_fwd #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         st_decode,
    input  logic         st_hdr,
    input  logic         st_load,
    input  logic         st_replay,
    input  logic         in_valid,
    input  logic         fifo_full,
    input  logic [W-1:0] in_byte,
    output logic [W-1:0] out_byte,
    output logic [W-1:0] hdr_byte
);
    import pdp_pkg::*;

    typedef struct packed {
        logic [W-1:0] hdr;
        logic [W-1:0] stash;
        logic [W-1:0] dout;
    } fwd_t;

    fwd_t     st_d, st_q;
    out_sel_t sel;

    always_comb begin
        st_d = st_q;
        sel  = pick_src(st_hdr, st_load, fifo_full, st_replay);
        if (st_decode && in_valid)
            st_d.hdr = in_byte;
        if (st_load && fifo_full)
            st_d.stash = in_byte;
        case (sel)
            SEL_HDR:   st_d.dout = st_q.hdr;
            SEL_LIVE:  st_d.dout = in_byte;
            SEL_STASH: st_d.dout = st_q.stash;
            default:   st_d.dout = st_q.dout;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_byte = st_q.dout;
    assign hdr_byte = st_q.hdr;
endmodule

// File: rtl/pdp_flags.sv
module pdp_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic st_decode,
    input  logic st_load,
    input  logic st_replay,
    input  logic clr_low,
    input  logic in_valid,
    input  logic fifo_full,
    output logic par_done,
    output logic low_valid
);
    typedef struct packed {
        logic done;
        logic low;
    } flg_t;

    flg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_decode)
            st_d.done = 1'b0;
        else if ((st_load && !fifo_full && !in_valid) ||
                 (st_replay && st_q.low && !st_q.done))
            st_d.done = 1'b1;

        if (clr_low)
            st_d.low = 1'b0;
        else if (st_load && !in_valid)
            st_d.low = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign par_done  = st_q.done;
    assign low_valid = st_q.low;
endmodule

// File: rtl/pdp_parity.sv
module pdp_parity #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         st_decode,
    input  logic         st_hdr,
    input  logic         st_load,
    input  logic         st_stall,
    input  logic         in_valid,
    input  logic [W-1:0] in_byte,
    input  logic [W-1:0] hdr_byte,
    input  logic         par_done,
    output logic [W-1:0] ipar,
    output logic [W-1:0] ppar,
    output logic         par_err
);
    typedef struct packed {
        logic [W-1:0] ipar;
        logic [W-1:0] ppar;
        logic         done_dly;
        logic         err;
    } par_t;

    par_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.done_dly = par_done;
        if (st_decode)
            st_d.ipar = '0;
        else if (!st_stall) begin
            if (st_hdr)
                st_d.ipar = st_q.ipar ^ hdr_byte;
            else if (st_load && in_valid)
                st_d.ipar = st_q.ipar ^ in_byte;
        end
        if (st_load && !in_valid)
            st_d.ppar = in_byte;
        if (par_done && !st_q.done_dly)
            st_d.err = (st_q.ipar != st_q.ppar);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ipar    = st_q.ipar;
    assign ppar    = st_q.ppar;
    assign par_err = st_q.err;
endmodule

// File: rtl/pkt_datapath.sv
module pkt_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_byte,
    input  logic         fifo_full,
    input  logic         st_decode,
    input  logic         st_hdr,
    input  logic         st_load,
    input  logic         st_stall,
    input  logic         st_replay,
    input  logic         clr_low,
    output logic [W-1:0] out_byte,
    output logic         par_done,
    output logic         low_valid,
    output logic         par_err
);
    logic [W-1:0] hdr_w;
    logic [W-1:0] ipar_w;
    logic [W-1:0] ppar_w;

    pdp_fwd #(.W(W)) u_fwd (
        .clk(clk), .rst_n(rst_n),
        .st_decode(st_decode), .st_hdr(st_hdr), .st_load(st_load),
        .st_replay(st_replay), .in_valid(in_valid), .fifo_full(fifo_full),
        .in_byte(in_byte), .out_byte(out_byte), .hdr_byte(hdr_w)
    );

    pdp_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .st_decode(st_decode), .st_load(st_load), .st_replay(st_replay),
        .clr_low(clr_low), .in_valid(in_valid), .fifo_full(fifo_full),
        .par_done(par_done), .low_valid(low_valid)
    );

    pdp_parity #(.W(W)) u_par (
        .clk(clk), .rst_n(rst_n),
        .st_decode(st_decode), .st_hdr(st_hdr), .st_load(st_load),
        .st_stall(st_stall), .in_valid(in_valid), .in_byte(in_byte),
        .hdr_byte(hdr_w), .par_done(par_done),
        .ipar(ipar_w), .ppar(ppar_w), .par_err(par_err)
    );
endmodule

// File: rtl/pdp_datapath_chk.sv
module pdp_datapath_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] in_byte,
    input logic         fifo_full,
    input logic         st_decode,
    input logic         st_hdr,
    input logic         st_load,
    input logic         st_stall,
    input logic         st_replay,
    input logic         clr_low,
    input logic [W-1:0] out_byte,
    input logic         par_done,
    input logic         low_valid,
    input logic         par_err,
    input logic [W-1:0] ipar,
    input logic [W-1:0] ppar
);
    AST_LIVE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_load && !fifo_full && !st_hdr) |=> out_byte == $past(in_byte)); // R3

    AST_STALL_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_load && fifo_full && !st_hdr && !st_replay) |=> $stable(out_byte)); // R4

    AST_DECODE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        st_decode |=> !par_done); // R5

    AST_LOW_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_low |=> !low_valid); // R6

    AST_LOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_load && !in_valid && !clr_low) |=> low_valid); // R6

    AST_STALL_FREEZES_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_stall && !st_decode) |=> $stable(ipar)); // R7

    AST_ERR_ON_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_done) |=> par_err == $past(ipar != ppar)); // R8

    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(par_done) |=> $stable(par_err)); // R8
endmodule

bind pkt_datapath pdp_datapath_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .fifo_full(fifo_full), .st_decode(st_decode), .st_hdr(st_hdr),
    .st_load(st_load), .st_stall(st_stall), .st_replay(st_replay),
    .clr_low(clr_low), .out_byte(out_byte), .par_done(par_done),
    .low_valid(low_valid), .par_err(par_err), .ipar(ipar_w), .ppar(ppar_w)
);

// File: tb/sim_pkt_datapath.sv
module sim_pkt_datapath;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    // strobe vector: {decode, hdr, load, stall, replay, clr_low}
    localparam logic [5:0] S_IDLE = 6'b000000;
    localparam logic [5:0] S_DEC  = 6'b100000;
    localparam logic [5:0] S_HDR  = 6'b010000;
    localparam logic [5:0] S_LOAD = 6'b001000;
    localparam logic [5:0] S_STL  = 6'b000100;
    localparam logic [5:0] S_RPL  = 6'b000010;
    localparam logic [5:0] S_CLR  = 6'b000001;

    typedef struct packed {
        logic [7:0] hdr;
        logic [3:0] len;
        logic [7:0] seed;
        logic       bad;
        logic       exp_err;
    } pkt_vec_t;

    localparam pkt_vec_t PKTS [6] = '{
        '{8'h01, 4'd1, 8'h10, 1'b0, 1'b0},
        '{8'h02, 4'd4, 8'h5A, 1'b1, 1'b1},
        '{8'hC2, 4'd0, 8'h00, 1'b0, 1'b0},
        '{8'h41, 4'd7, 8'hF3, 1'b0, 1'b0},
        '{8'h80, 4'd0, 8'h00, 1'b1, 1'b1},
        '{8'h3E, 4'd15, 8'h21, 1'b1, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_byte = '0;
    logic         fifo_full = 1'b0;
    logic [5:0]   stb = '0;
    logic [W-1:0] out_byte;
    logic         par_done, low_valid, par_err;

    int nchk = 0;
    int nerr = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_datapath #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .fifo_full(fifo_full), .st_decode(stb[5]), .st_hdr(stb[4]),
        .st_load(stb[3]), .st_stall(stb[2]), .st_replay(stb[1]),
        .clr_low(stb[0]), .out_byte(out_byte), .par_done(par_done),
        .low_valid(low_valid), .par_err(par_err)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic cyc(input logic [5:0] s, input logic v, input logic [W-1:0] b,
                       input logic full);
        @(negedge clk);
        stb = s; in_valid = v; in_byte = b; fifo_full = full;
        @(posedge clk);
        #1;
    endtask

    task automatic send_pkt(input pkt_vec_t p);
        logic [7:0] par;
        logic [7:0] pb;
        par = p.hdr;
        cyc(S_DEC, 1'b1, p.hdr, 1'b0);
        chk("R5 decode clears done", par_done, 0);
        cyc(S_HDR, 1'b0, 8'h00, 1'b0);
        chk("R2 header on out", out_byte, p.hdr);
        for (int i = 0; i < int'(p.len); i++) begin
            pb = p.seed + 8'(i * 7);
            par ^= pb;
            cyc(S_LOAD, 1'b1, pb, 1'b0);
            chk("R3 payload forwarded", out_byte, pb);
        end
        pb = p.bad ? (par ^ 8'h01) : par;
        cyc(S_LOAD, 1'b0, pb, 1'b0);
        chk("R3 parity byte forwarded", out_byte, pb);
        chk("R5 done set on parity", par_done, 1);
        chk("R6 low set", low_valid, 1);
        cyc(S_CLR, 1'b0, 8'hA5, 1'b1);
        chk("R6 low cleared", low_valid, 0);
        chk("R8 err evaluated", par_err, p.exp_err);
        cyc(S_IDLE, 1'b1, 8'h77, 1'b0);
        chk("R8 err holds", par_err, p.exp_err);
        chk("R9 out holds when idle", out_byte, pb);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 out reset", out_byte, 0);
        chk("R1 done reset", par_done, 0);
        chk("R1 low reset", low_valid, 0);
        chk("R1 err reset", par_err, 0);
        @(negedge clk) rst_n = 1'b1;

        foreach (PKTS[k]) send_pkt(PKTS[k]);

        // R4/R5/R7: stall on payload and on parity, both replayed
        cyc(S_DEC, 1'b1, 8'h3C, 1'b0);
        cyc(S_HDR, 1'b0, 8'h00, 1'b0);
        cyc(S_LOAD, 1'b1, 8'h11, 1'b0);
        chk("R3 first payload", out_byte, 8'h11);
        cyc(S_LOAD, 1'b1, 8'h22, 1'b1);
        chk("R4 stalled byte not forwarded", out_byte, 8'h11);
        cyc(S_STL, 1'b1, 8'h99, 1'b1);
        chk("R4 out holds in stall", out_byte, 8'h11);
        cyc(S_RPL, 1'b1, 8'h55, 1'b0);
        chk("R4 held byte replayed", out_byte, 8'h22);
        chk("R5 no done on replay without low", par_done, 0);
        cyc(S_LOAD, 1'b1, 8'h33, 1'b0);
        chk("R3 payload after replay", out_byte, 8'h33);
        cyc(S_LOAD, 1'b0, 8'h3C ^ 8'h11 ^ 8'h22 ^ 8'h33, 1'b1);
        chk("R4 parity stalled", out_byte, 8'h33);
        chk("R6 low set while full", low_valid, 1);
        chk("R5 no done while full", par_done, 0);
        cyc(S_STL, 1'b1, 8'hEE, 1'b1);
        cyc(S_RPL, 1'b0, 8'h00, 1'b0);
        chk("R4 parity replayed", out_byte, 8'h3C ^ 8'h11 ^ 8'h22 ^ 8'h33);
        chk("R5 done set on replay", par_done, 1);
        cyc(S_CLR, 1'b0, 8'h00, 1'b0);
        chk("R7 stall byte counted once", par_err, 0);

        // R2: decode without valid keeps old header
        cyc(S_DEC, 1'b0, 8'h77, 1'b0);
        chk("R5 decode clears done", par_done, 0);
        cyc(S_HDR, 1'b0, 8'h00, 1'b0);
        chk("R2 header kept when valid low", out_byte, 8'h3C);

        // R6: clear beats set
        cyc(S_LOAD | S_CLR, 1'b0, 8'h3C, 1'b0);
        chk("R6 clear has priority", low_valid, 0);
        chk("R5 done set", par_done, 1);
        cyc(S_IDLE, 1'b0, 8'h12, 1'b1);
        chk("R8 err after matching parity", par_err, 0);
        chk("R9 low holds when idle", low_valid, 0);

        // R1: reset mid-run after an error
        send_pkt(PKTS[1]);
        @(negedge clk) rst_n = 1'b0;
        #1;
        chk("R1 out cleared", out_byte, 0);
        chk("R1 done cleared", par_done, 0);
        chk("R1 err cleared", par_err, 0);
        @(negedge clk) rst_n = 1'b1;
        cyc(S_IDLE, 1'b0, 8'h00, 1'b0);

        done_flag = 1;
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule